// File: doc/BRIEF.md
# Prescaled Counter Timer with Single-Edge PWM Outputs

This block is a 16-bit up-counter driven by a programmable prescaler. Four compare values are held in the block. The highest-numbered one sets the length of the cycle, and the other three each control one output pin. Each output pin runs in one of two modes, chosen by its own enable bit. In PWM mode the pin goes high when the counter reaches that channel's compare value, and it drops when the cycle restarts. In the other mode the pin simply copies a software-held level bit.

The counter and the prescaler can also be zeroed by an edge on one of two asynchronous capture pins. A three-bit selector picks the pin and the edge, and a separate enable bit gates this clear. The capture pins pass through two synchronizer stages, and the edge detector compares the two newest synchronized samples.

All settings are written through a plain write port (strobe, address, data). The running count is visible on `countOut`, so firmware and neighbouring logic can follow the timer.

Top module: `pwm_match_timer`

## Requirements
- R1: Synchronous active-high reset clears the count, the prescaler and every setting, so `countOut` is 0 and all `matchOut` pins are 0 after reset.
- R2: With run bit 0 of address 0 set and a prescale value P written at address 1, the count goes up by exactly one every P+1 clocks. While the run bit is clear, the count holds.
- R3: The count runs from 0 up to the cycle compare value written at address 7. On the next prescaler wrap it returns to 0.
- R4: A channel whose PWM enable bit is 0 drives its pin with its level bit. Address 3 carries the PWM enables in bits 2:0 and the level bits in bits 6:4. A new level appears on the pin one clock after the write.
- R5: A PWM-enabled channel n (n = 0..2, compare value at address 4+n) sets its pin high on the prescaler wrap that advances the count to that compare value.
- R6: Every PWM-enabled pin is low after any return of the count to 0, whether the return comes from the cycle compare or from a capture clear.
- R7: A PWM-enabled channel whose compare value is 0 or above the cycle compare value never goes high.
- R8: With address 2 bit 4 set, bits 7:5 select the clearing edge: 0 is a rise on capture pin 0, 1 is a fall on pin 0, 2 is a rise on pin 1 and 3 is a fall on pin 1. The selected edge zeroes the count and the prescaler on the third rising clock edge after the pin changes.
- R9: Selector codes 4 to 7, or address 2 bit 4 at 0, make capture edges have no effect on the count.
- R10: When a capture clear and a cycle-compare wrap fall on the same clock, the count goes to 0 once, PWM pins are low, and counting continues from 0 on the next prescaler wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the setting registers |
| wrAddr | input | 3 | Register address (0 run, 1 prescale, 2 capture clear, 3 output config, 4..7 compare values) |
| wrData | input | 16 | Write data |
| capIn | input | 2 | Asynchronous capture pins |
| countOut | output | 16 | Current count |
| matchOut | output | 3 | Channel output pins |

## Verification
A register write takes effect on the clock edge that samples it. A level bit therefore shows on its pin at the first falling edge after that write. A prescaler wrap updates `countOut`, and any PWM pin it sets, on the same rising edge. A capture-pin change zeroes the count on the third rising edge after it. The bench changes inputs only on falling edges and samples outputs on falling edges. Its directed checks count rising edges from the stimulus to the expected result. A cycle-level reference model, rebuilt from the requirements, is compared with both outputs at every falling edge during mixed random traffic.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  // Register addresses; the compare registers sit at the top of the map.
  localparam int unsigned ADDR_RUN       = 0;
  localparam int unsigned ADDR_PRESCALE  = 1;
  localparam int unsigned ADDR_CAPCLR    = 2;
  localparam int unsigned ADDR_OUTCFG    = 3;
  localparam int unsigned ADDR_CMP_BASE  = 4;

  // Field positions inside the capture-clear and output-config words.
  localparam int unsigned CAPCLR_EN_BIT  = 4;
  localparam int unsigned CAPCLR_SEL_LSB = 5;
  localparam int unsigned LEVEL_LSB      = 4;

  // Strobes from control to datapath, one clock wide.
  typedef struct packed {
    logic tick;      // prescaler wrapped while running
    logic capClear;  // selected capture edge seen
  } pmtStrobe_t;
endpackage

// File: rtl/pmt_ctrl.sv
module pmt_ctrl
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_PWM = 3,
  parameter int unsigned ADDR_W  = 3,
  localparam int unsigned NUM_CMP = NUM_PWM + 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [CNT_W-1:0]                 wrData,
  input  logic [1:0]                       capIn,
  output pmtStrobe_t                       strobe,
  output logic [NUM_CMP-1:0][CNT_W-1:0]    cmpVals,
  output logic [NUM_PWM-1:0]               pwmEn,
  output logic [NUM_PWM-1:0]               levelBits
);
  logic             runQ;
  logic [CNT_W-1:0] preValQ;
  logic [CNT_W-1:0] preCntQ;
  logic             capClrEnQ;
  logic [2:0]       capSelQ;
  logic [1:0]       syncA, syncB, syncC;
  logic [1:0]       riseV, fallV;
  logic             edgeHit;
  logic             capClear;
  logic             preWrap;

  // Setting registers
  always_ff @(posedge clk) begin
    if (rst) begin
      runQ      <= 1'b0;
      preValQ   <= '0;
      capClrEnQ <= 1'b0;
      capSelQ   <= '0;
      pwmEn     <= '0;
      levelBits <= '0;
    end else if (wrEn) begin
      case (int'(wrAddr))
        ADDR_RUN:      runQ <= wrData[0];
        ADDR_PRESCALE: preValQ <= wrData;
        ADDR_CAPCLR: begin
          capClrEnQ <= wrData[CAPCLR_EN_BIT];
          capSelQ   <= wrData[CAPCLR_SEL_LSB +: 3];
        end
        ADDR_OUTCFG: begin
          pwmEn     <= wrData[NUM_PWM-1:0];
          levelBits <= wrData[LEVEL_LSB +: NUM_PWM];
        end
        default: ;
      endcase
    end
  end

  // Compare registers, one per channel plus the cycle-length one
  for (genvar g = 0; g < NUM_CMP; g++) begin : gCmp
    always_ff @(posedge clk) begin
      if (rst) cmpVals[g] <= '0;
      else if (wrEn && int'(wrAddr) == ADDR_CMP_BASE + g) cmpVals[g] <= wrData;
    end
  end

  // Two-stage synchronizer plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= capIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign riseV = syncB & ~syncC;
  assign fallV = ~syncB & syncC;

  always_comb begin
    case (capSelQ)
      3'd0:    edgeHit = riseV[0];
      3'd1:    edgeHit = fallV[0];
      3'd2:    edgeHit = riseV[1];
      3'd3:    edgeHit = fallV[1];
      default: edgeHit = 1'b0;
    endcase
  end

  assign capClear = capClrEnQ & edgeHit;
  assign preWrap  = preCntQ >= preValQ;

  // Prescaler; a capture clear resets it even when stopped
  always_ff @(posedge clk) begin
    if (rst || capClear)   preCntQ <= '0;
    else if (runQ) begin
      if (preWrap) preCntQ <= '0;
      else         preCntQ <= preCntQ + 1'b1;
    end
  end

  assign strobe.tick     = runQ & preWrap & ~capClear;
  assign strobe.capClear = capClear;
endmodule

// File: rtl/pmt_datapath.sv
module pmt_datapath
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_PWM = 3,
  localparam int unsigned NUM_CMP = NUM_PWM + 1,
  localparam int unsigned CYC_IDX = NUM_PWM
) (
  input  logic                          clk,
  input  logic                          rst,
  input  pmtStrobe_t                    strobe,
  input  logic [NUM_CMP-1:0][CNT_W-1:0] cmpVals,
  input  logic [NUM_PWM-1:0]            pwmEn,
  input  logic [NUM_PWM-1:0]            levelBits,
  output logic [CNT_W-1:0]              countOut,
  output logic [NUM_PWM-1:0]            matchOut
);
  logic [CNT_W-1:0]   cntQ;
  logic [CNT_W-1:0]   nextCnt;
  logic               cycleHit;
  logic               zeroing;
  logic [NUM_PWM-1:0] pwmQ;

  assign nextCnt  = cntQ + 1'b1;
  assign cycleHit = strobe.tick && (cntQ == cmpVals[CYC_IDX]);
  assign zeroing  = strobe.capClear | cycleHit;

  always_ff @(posedge clk) begin
    if (rst || zeroing)   cntQ <= '0;
    else if (strobe.tick) cntQ <= nextCnt;
  end

  for (genvar g = 0; g < NUM_PWM; g++) begin : gChan
    always_ff @(posedge clk) begin
      if (rst || !pwmEn[g] || zeroing)                   pwmQ[g] <= 1'b0;
      else if (strobe.tick && nextCnt == cmpVals[g])     pwmQ[g] <= 1'b1;
    end
    assign matchOut[g] = pwmEn[g] ? pwmQ[g] : levelBits[g];
  end

  assign countOut = cntQ;
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_PWM = 3,
  parameter int unsigned ADDR_W  = 3,
  localparam int unsigned NUM_CMP = NUM_PWM + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [1:0]         capIn,
  output logic [CNT_W-1:0]   countOut,
  output logic [NUM_PWM-1:0] matchOut
);
  pmtStrobe_t                    strobeW;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmpValsW;
  logic [NUM_PWM-1:0]            pwmEnW;
  logic [NUM_PWM-1:0]            levelBitsW;

  pmt_ctrl #(.CNT_W(CNT_W), .NUM_PWM(NUM_PWM), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .capIn(capIn), .strobe(strobeW), .cmpVals(cmpValsW), .pwmEn(pwmEnW),
    .levelBits(levelBitsW)
  );

  pmt_datapath #(.CNT_W(CNT_W), .NUM_PWM(NUM_PWM)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobeW), .cmpVals(cmpValsW),
    .pwmEn(pwmEnW), .levelBits(levelBitsW), .countOut(countOut),
    .matchOut(matchOut)
  );
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_PWM = 3,
  localparam int unsigned NUM_CMP = NUM_PWM + 1
) (
  input logic                          clk,
  input logic                          rst,
  input logic [CNT_W-1:0]              countOut,
  input logic [NUM_PWM-1:0]            matchOut,
  input logic [NUM_PWM-1:0]            pwmEn,
  input logic [NUM_CMP-1:0][CNT_W-1:0] cmpVals
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (countOut != $past(countOut)) |-> (countOut == '0 || countOut == $past(countOut) + 1'b1)); // R2

  AST_WRAP_AT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ($past(countOut) == $past(cmpVals[NUM_PWM]) && countOut != $past(countOut)) |-> countOut == '0); // R3

  AST_PWM_LOW_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (countOut == '0 && $past(countOut) != '0) |-> (matchOut & pwmEn) == '0); // R6

  for (genvar g = 0; g < NUM_PWM; g++) begin : gRise
    AST_PWM_RISE_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
      ($rose(matchOut[g]) && pwmEn[g] && $past(pwmEn[g])) |-> countOut == $past(cmpVals[g])); // R5
  end
endmodule

bind pwm_match_timer pmt_checker #(.CNT_W(CNT_W), .NUM_PWM(NUM_PWM)) u_chk (
  .clk(clk), .rst(rst), .countOut(countOut), .matchOut(matchOut),
  .pwmEn(pwmEnW), .cmpVals(cmpValsW)
);

// File: tb/pwm_match_timer_tb.sv
`timescale 1ns/1ps
module pwm_match_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  capIn = '0;
  logic [15:0] countOut;
  logic [2:0]  matchOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwm_match_timer u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .capIn(capIn), .countOut(countOut), .matchOut(matchOut)
  );

  // ---------------- reference model built from the requirements ----------------
  logic        mRun, mClrEn;
  logic [2:0]  mSel, mPwmEn, mLevel, mPwmQ;
  logic [15:0] mPreVal, mPre, mCnt;
  logic [15:0] mCmp [4];
  logic [1:0]  mS1, mS2, mS3;
  logic        tClr, tTick, tWrap, tHit;
  logic [15:0] tNext;

  function automatic logic selEdge(input logic [2:0] sel, input logic [1:0] cur, input logic [1:0] old);
    case (sel)
      3'd0: return cur[0] & ~old[0];
      3'd1: return ~cur[0] & old[0];
      3'd2: return cur[1] & ~old[1];
      3'd3: return ~cur[1] & old[1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] modelPins();
    logic [2:0] p;
    for (int i = 0; i < 3; i++) p[i] = mPwmEn[i] ? mPwmQ[i] : mLevel[i];
    return p;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mRun = 0; mClrEn = 0; mSel = 0; mPwmEn = 0; mLevel = 0; mPwmQ = 0;
      mPreVal = 0; mPre = 0; mCnt = 0; mS1 = 0; mS2 = 0; mS3 = 0;
      for (int i = 0; i < 4; i++) mCmp[i] = 0;
    end else begin
      tClr  = mClrEn && selEdge(mSel, mS2, mS3);
      tTick = mRun && (mPre >= mPreVal) && !tClr;
      tWrap = tTick && (mCnt == mCmp[3]);
      tNext = mCnt + 16'd1;
      for (int i = 0; i < 3; i++) begin
        tHit = tTick && (tNext == mCmp[i]);
        if (!mPwmEn[i] || tClr || tWrap) mPwmQ[i] = 1'b0;
        else if (tHit) mPwmQ[i] = 1'b1;
      end
      if (tClr) mPre = 0;
      else if (mRun) mPre = (mPre >= mPreVal) ? 16'd0 : mPre + 16'd1;
      if (tClr || tWrap) mCnt = 0;
      else if (tTick) mCnt = tNext;
      mS3 = mS2; mS2 = mS1; mS1 = capIn;
      if (wrEn) begin
        case (wrAddr)
          3'd0: mRun = wrData[0];
          3'd1: mPreVal = wrData;
          3'd2: begin mClrEn = wrData[4]; mSel = wrData[7:5]; end
          3'd3: begin mPwmEn = wrData[2:0]; mLevel = wrData[6:4]; end
          default: mCmp[wrAddr - 3'd4] = wrData;
        endcase
      end
    end
  end

  // Continuous comparison against the model at every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      nTests++;
      if (countOut !== mCnt) begin
        nFail++;
        $display("FAIL R3 model count: actual %0d expected %0d", countOut, mCnt);
      end
      nTests++;
      if (matchOut !== modelPins()) begin
        nFail++;
        $display("FAIL R5 model pins: actual %b expected %b", matchOut, modelPins());
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1; capIn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic pin0Exp(input int c);
    return (c >= 2 && c <= 5);
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] snap;
    void'($urandom(32'h5EED_0123));
    doReset();
    check("R1 count after reset", countOut, 16'd0);
    check("R1 pins after reset", {13'd0, matchOut}, 16'd0);

    // PWM cycle: length 5, ch0 at 2, ch1 beyond cycle, ch2 at zero
    regWrite(3'd7, 16'd5);
    regWrite(3'd4, 16'd2);
    regWrite(3'd5, 16'd9);
    regWrite(3'd6, 16'd0);
    regWrite(3'd3, 16'h0007);
    regWrite(3'd1, 16'd0);
    regWrite(3'd0, 16'd1);
    for (int n = 1; n <= 18; n++) begin
      @(negedge clk);
      check("R3 cycle count", countOut, 16'(n % 6));
      check((n % 6 == 0) ? "R6 pin0 low at wrap" : "R5 pin0", {15'd0, matchOut[0]}, {15'd0, pin0Exp(n % 6)});
      check("R7 pin1 beyond cycle", {15'd0, matchOut[1]}, 16'd0);
      check("R7 pin2 zero compare", {15'd0, matchOut[2]}, 16'd0);
    end

    // Level mode: enables off, levels 101
    regWrite(3'd3, 16'h0050);
    check("R4 level pins", {13'd0, matchOut}, 16'd5);
    regWrite(3'd3, 16'h0020);
    check("R4 level pins", {13'd0, matchOut}, 16'd2);

    // Prescaler
    doReset();
    regWrite(3'd7, 16'd100);
    regWrite(3'd1, 16'd2);
    regWrite(3'd0, 16'd1);
    repeat (6) @(negedge clk);
    check("R2 prescale 2 after 6 clocks", countOut, 16'd2);
    repeat (3) @(negedge clk);
    check("R2 prescale 2 after 9 clocks", countOut, 16'd3);
    regWrite(3'd0, 16'd0);
    snap = countOut;
    repeat (10) @(negedge clk);
    check("R2 hold while stopped", countOut, snap);

    // Capture clear timing, rising edge of pin 0
    doReset();
    regWrite(3'd7, 16'd1000);
    regWrite(3'd1, 16'd0);
    regWrite(3'd2, 16'h0010);
    regWrite(3'd0, 16'd1);
    repeat (20) @(negedge clk);
    capIn[0] = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 no clear before third edge", {15'd0, countOut == 16'd0}, 16'd0);
    @(negedge clk);
    check("R8 clear on third edge", countOut, 16'd0);
    @(negedge clk);
    check("R8 count resumes", countOut, 16'd1);

    // Falling edge of pin 1 (code 3)
    capIn[1] = 1'b1;
    regWrite(3'd2, 16'h0070);
    repeat (10) @(negedge clk);
    capIn[1] = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 fall on pin1 clears", countOut, 16'd0);

    // Reserved code and disabled clear
    regWrite(3'd2, 16'h00B0);
    repeat (10) @(negedge clk);
    snap = countOut;
    capIn[0] = 1'b0;
    repeat (4) @(negedge clk);
    capIn[0] = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 reserved code no clear", countOut, snap + 16'd8);
    regWrite(3'd2, 16'h0000);
    snap = countOut;
    capIn[0] = 1'b0;
    repeat (4) @(negedge clk);
    capIn[0] = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 clear disabled", countOut, snap + 16'd8);

    // Capture clear on the same clock as the cycle wrap
    doReset();
    regWrite(3'd7, 16'd5);
    regWrite(3'd4, 16'd2);
    regWrite(3'd3, 16'h0001);
    regWrite(3'd2, 16'h0050);
    regWrite(3'd0, 16'd1);
    while (countOut != 16'd3) @(negedge clk);
    capIn[1] = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 count zero on joint event", countOut, 16'd0);
    check("R10 pin low on joint event", {15'd0, matchOut[0]}, 16'd0);
    @(negedge clk);
    check("R10 count resumes at one", countOut, 16'd1);
    @(negedge clk);
    check("R10 pin sets again", {15'd0, matchOut[0]}, 16'd1);

    // Constrained random traffic against the model
    doReset();
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(7) == 0) begin
        wrEn = 1'b1;
        wrAddr = 3'($urandom_range(7));
        case (wrAddr)
          3'd0: wrData = 16'($urandom_range(1));
          3'd1: wrData = 16'($urandom_range(3));
          3'd2: wrData = 16'($urandom_range(255));
          3'd3: wrData = 16'($urandom_range(127));
          default: wrData = 16'($urandom_range(12));
        endcase
      end else wrEn = 1'b0;
      if ($urandom_range(5) == 0) capIn[$urandom_range(1)] ^= 1'b1;
      @(negedge clk);
    end
    wrEn = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule